// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block sits between a system address bus and a set of external-memory chip selects. It holds one window word for each of eight chip selects. A window word carries a base, a size mask and a valid flag. It also holds a device-class field for each chip select and a small prefetch-engine claim register. Every cycle it decodes the incoming request address combinationally against those registered words. The result is a one-hot chip select, the offset of the address inside the selected window, and a route code. The route code says whether the access goes to a direct memory device, to the NAND command/data path, or to the prefetch FIFO port.

A window starts at its 6-bit base placed at address bit 24. Its size is set by a 4-bit mask, and only a handful of mask codes are legal. A legal mask gives a window of 16, 32, 64 or 128 MB, and 256 MB when the build option allows mask 0. An illegal mask still decodes with the size that the arithmetic gives, but it is flagged for every valid window that carries it. When two valid windows cover the same address, the lowest chip-select number takes the access and a multi-hit flag is raised. Configuration is written through a single write port that selects which word is being loaded.

Top module: `cs_window_decoder`

## Requirements
- R1: A window-word write (wr_kind 0) to chip select wr_cs stores only wr_data bits 11:8 (mask), bit 6 (valid) and bits 5:0 (base). Bit 7 and bits 31:12 are dropped and have no effect on decode.
- R2: After reset, every window word equals 0xF00 (mask 0xF, base 0, invalid), except chip select 0, which is valid. So addresses 0x00000000 to 0x00FFFFFF hit chip select 0, every other address misses, mask_err is zero, every device class is 0 and the prefetch claim is off.
- R3: A valid window covers the addresses A with base*2^24 <= A < base*2^24 + size, where size = (16 - mask) * 2^24.
- R4: A chip select whose valid bit is 0 never appears in cs_sel.
- R5: On a hit, cs_offset equals req_addr AND (size - 1) of the selected window.
- R6: mask_err[i] is 1 exactly when window i is valid and its mask is not 0x8, 0xC, 0xE or 0xF (mask 0x0 is also legal when ALLOW_FULL_MASK is 1).
- R7: When several valid windows hit, cs_sel is the one-hot bit of the lowest-numbered one, and multi_hit is 1. multi_hit is 0 when at most one window hits.
- R8: A device-class write (wr_kind 1) stores wr_data bits 11:10. On a hit, cs_route is 1 (direct memory) when that class is 0, and 2 (NAND path) otherwise.
- R9: A prefetch write (wr_kind 2) stores the claim enable from wr_data bit 7 and the claimed chip select from bits 26:24. A hit on a non-direct window whose number equals the claimed chip select, while the claim is enabled, routes to 3 (prefetch FIFO). Direct-memory windows are never rerouted.
- R10: A configuration write sampled at a rising edge changes the decode outputs from that edge onward, and not before.
- R11: With no hit, cs_sel, cs_hit, cs_offset, cs_route and multi_hit are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 2 | Word selector: 0 window, 1 device class, 2 prefetch claim |
| wr_cs | input | 3 | Chip select addressed by window and device-class writes |
| wr_data | input | 32 | Write data |
| req_addr | input | 32 | Address to decode |
| cs_sel | output | 8 | One-hot selected chip select |
| cs_hit | output | 1 | Some valid window covers req_addr |
| cs_offset | output | 32 | Offset inside the selected window |
| cs_route | output | 2 | 0 none, 1 direct, 2 NAND, 3 prefetch FIFO |
| multi_hit | output | 1 | More than one valid window covers req_addr |
| mask_err | output | 8 | Per chip select: valid window with an illegal mask |

## Verification
The bench probes the first and last byte of windows and the bytes just outside them. A decoder that compares the upper bound with `<=`, or that derives size as a power of two, selects the neighbouring address or loses the top slice of the window. It sweeps all sixteen mask codes on a valid window, so a wrong legal-set table shows up as a misflagged mask_err bit or a wrong size for the non-power-of-two codes. Overlapping valid windows expose a priority encoder that favours the highest number. The prefetch claim is moved across chip selects and device classes, so a decoder that reroutes a direct-memory window, or ignores the claim enable, reports the wrong route.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

  localparam int ADDR_W     = 32;
  localparam int BASE_SHIFT = 24;
  localparam int BASE_W     = 6;
  localparam int MASK_W     = 4;
  localparam int WORD_W     = 12;
  localparam int VALID_POS  = 6;

  localparam logic [WORD_W-1:0] WIN_KEEP  = 12'hF7F;
  localparam logic [WORD_W-1:0] WIN_RESET = 12'hF00;

  typedef enum logic [1:0] {
    ROUTE_NONE   = 2'd0,
    ROUTE_DIRECT = 2'd1,
    ROUTE_NAND   = 2'd2,
    ROUTE_FIFO   = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    WK_WINDOW   = 2'd0,
    WK_DEVICE   = 2'd1,
    WK_PREFETCH = 2'd2,
    WK_SPARE    = 2'd3
  } wkind_e;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic              spare;
    logic              valid;
    logic [BASE_W-1:0] base;
  } win_word_t;

  // Window byte count for a mask code, one bit wider than the address.
  function automatic logic [ADDR_W:0] win_span(input logic [MASK_W-1:0] m);
    logic [ADDR_W-1:0] lim;
    lim = 32'h0FFF_FFFF & ~{4'h0, m, 24'h0};
    return {1'b0, lim} + 33'd1;
  endfunction

  function automatic logic [ADDR_W-1:0] win_start(input logic [BASE_W-1:0] b);
    return {2'b00, b, 24'h0};
  endfunction

  function automatic logic mask_legal(input logic [MASK_W-1:0] m, input logic allow_full);
    return (m == 4'h8) || (m == 4'hC) || (m == 4'hE) || (m == 4'hF) ||
           (allow_full && (m == 4'h0));
  endfunction

endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import csdec_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CS_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [1:0]                    wr_kind,
  input  logic [CS_W-1:0]               wr_cs,
  input  logic [31:0]                   wr_data,
  output logic [NUM_CS-1:0][WORD_W-1:0] win_q,
  output logic [NUM_CS-1:0][1:0]        dev_q,
  output logic                          pf_en_q,
  output logic [CS_W-1:0]               pf_cs_q
);

  logic wr_window;
  logic wr_device;
  logic wr_prefetch;

  assign wr_window   = wr_en && (wkind_e'(wr_kind) == WK_WINDOW);
  assign wr_device   = wr_en && (wkind_e'(wr_kind) == WK_DEVICE);
  assign wr_prefetch = wr_en && (wkind_e'(wr_kind) == WK_PREFETCH);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    localparam logic [WORD_W-1:0] RST_WORD =
      (i == 0) ? (WIN_RESET | (12'h1 << VALID_POS)) : WIN_RESET;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_q[i] <= RST_WORD;
        dev_q[i] <= 2'b00;
      end else begin
        if (wr_window && (wr_cs == CS_W'(i))) win_q[i] <= wr_data[WORD_W-1:0] & WIN_KEEP;
        if (wr_device && (wr_cs == CS_W'(i))) dev_q[i] <= wr_data[11:10];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_en_q <= 1'b0;
      pf_cs_q <= '0;
    end else if (wr_prefetch) begin
      pf_en_q <= wr_data[7];
      pf_cs_q <= wr_data[24 +: CS_W];
    end
  end

  p_win_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_window |=> (win_q[$past(wr_cs)] == ($past(wr_data[WORD_W-1:0]) & WIN_KEEP)));

  p_pf_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prefetch |=> (pf_en_q == $past(wr_data[7])));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(win_q) && $stable(dev_q) && $stable(pf_en_q) && $stable(pf_cs_q)));

endmodule

// File: rtl/cs_window_match.sv
module cs_window_match
  import csdec_pkg::*;
#(
  parameter bit ALLOW_FULL_MASK = 1'b0
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        dev_i,
  input  logic              fifo_claim_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] offset_o,
  output logic [1:0]        route_o,
  output logic              bad_mask_o
);

  win_word_t         w;
  logic [ADDR_W:0]   span;
  logic [ADDR_W:0]   lo;
  logic [ADDR_W:0]   hi;
  logic [ADDR_W:0]   a_ext;
  route_e            rt;

  assign w     = win_word_t'(word_i);
  assign span  = win_span(w.mask);
  assign lo    = {1'b0, win_start(w.base)};
  assign hi    = lo + span;
  assign a_ext = {1'b0, addr_i};

  assign hit_o      = w.valid && (a_ext >= lo) && (a_ext < hi);
  assign offset_o   = addr_i & (span[ADDR_W-1:0] - 32'd1);
  assign bad_mask_o = w.valid && !mask_legal(w.mask, ALLOW_FULL_MASK);

  always_comb begin
    if (dev_i == 2'b00)    rt = ROUTE_DIRECT;
    else if (fifo_claim_i) rt = ROUTE_FIFO;
    else                   rt = ROUTE_NAND;
  end
  assign route_o = rt;

endmodule

// File: rtl/cs_priority_pick.sv
module cs_priority_pick
  import csdec_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CS-1:0]             hits_i,
  input  logic [NUM_CS-1:0][ADDR_W-1:0] offs_i,
  input  logic [NUM_CS-1:0][1:0]        routes_i,
  output logic [NUM_CS-1:0]             sel_o,
  output logic                          any_o,
  output logic                          multi_o,
  output logic [ADDR_W-1:0]             offset_o,
  output logic [1:0]                    route_o
);

  localparam int CNT_W = $clog2(NUM_CS + 1);

  logic [CNT_W-1:0] n_hits;

  assign sel_o = hits_i & (~hits_i + NUM_CS'(1));
  assign any_o = |hits_i;

  always_comb begin
    n_hits   = '0;
    offset_o = '0;
    route_o  = ROUTE_NONE;
    for (int i = 0; i < NUM_CS; i++) begin
      n_hits = n_hits + CNT_W'(hits_i[i]);
      if (sel_o[i]) begin
        offset_o = offs_i[i];
        route_o  = routes_i[i];
      end
    end
  end

  assign multi_o = (n_hits > CNT_W'(1));

  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o) && ((sel_o & ~hits_i) == '0));

  p_multi_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    multi_o |-> ($countones(hits_i) >= 2) && any_o);

  p_quiet_on_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_o |-> (offset_o == '0) && (route_o == ROUTE_NONE) && (sel_o == '0));

endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import csdec_pkg::*;
#(
  parameter int NUM_CS          = 8,
  parameter bit ALLOW_FULL_MASK = 1'b0,
  localparam int CS_W           = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [CS_W-1:0]   wr_cs,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       req_addr,
  output logic [NUM_CS-1:0] cs_sel,
  output logic              cs_hit,
  output logic [31:0]       cs_offset,
  output logic [1:0]        cs_route,
  output logic              multi_hit,
  output logic [NUM_CS-1:0] mask_err
);

  logic [NUM_CS-1:0][WORD_W-1:0] win_q;
  logic [NUM_CS-1:0][1:0]        dev_q;
  logic                          pf_en_q;
  logic [CS_W-1:0]               pf_cs_q;

  logic [NUM_CS-1:0]             hits;
  logic [NUM_CS-1:0][ADDR_W-1:0] offs;
  logic [NUM_CS-1:0][1:0]        routes;
  logic [NUM_CS-1:0]             valid_vec;
  logic [NUM_CS-1:0]             claim_vec;

  cs_cfg_regs #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_kind (wr_kind),
    .wr_cs   (wr_cs),
    .wr_data (wr_data),
    .win_q   (win_q),
    .dev_q   (dev_q),
    .pf_en_q (pf_en_q),
    .pf_cs_q (pf_cs_q)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_win
    assign valid_vec[i] = win_q[i][VALID_POS];
    assign claim_vec[i] = pf_en_q && (pf_cs_q == CS_W'(i));

    cs_window_match #(.ALLOW_FULL_MASK(ALLOW_FULL_MASK)) u_match (
      .word_i       (win_q[i]),
      .dev_i        (dev_q[i]),
      .fifo_claim_i (claim_vec[i]),
      .addr_i       (req_addr),
      .hit_o        (hits[i]),
      .offset_o     (offs[i]),
      .route_o      (routes[i]),
      .bad_mask_o   (mask_err[i])
    );
  end

  cs_priority_pick #(.NUM_CS(NUM_CS)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .hits_i   (hits),
    .offs_i   (offs),
    .routes_i (routes),
    .sel_o    (cs_sel),
    .any_o    (cs_hit),
    .multi_o  (multi_hit),
    .offset_o (cs_offset),
    .route_o  (cs_route)
  );

  p_invalid_no_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel & ~valid_vec) == '0);

  p_mask_err_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_err & ~valid_vec) == '0);

  p_fifo_needs_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_route == ROUTE_FIFO) |-> (pf_en_q && ((cs_sel & claim_vec) != '0)));

  p_direct_never_fifo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_sel & claim_vec) != '0) && (cs_route != ROUTE_FIFO) |-> (cs_route == ROUTE_DIRECT));

endmodule

// File: tb/tb_cs_window_decoder.sv
module tb_cs_window_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = 2'd0;
  logic [2:0]  wr_cs = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] req_addr = 32'd0;
  logic [7:0]  cs_sel;
  logic        cs_hit;
  logic [31:0] cs_offset;
  logic [1:0]  cs_route;
  logic        multi_hit;
  logic [7:0]  mask_err;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R2";

  // Reference configuration state
  logic [11:0] m_win [8];
  logic [1:0]  m_dev [8];
  bit          m_pfen;
  int          m_pfcs;

  always #10 clk = ~clk;

  cs_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_cs(wr_cs),
    .wr_data(wr_data), .req_addr(req_addr), .cs_sel(cs_sel), .cs_hit(cs_hit),
    .cs_offset(cs_offset), .cs_route(cs_route), .multi_hit(multi_hit), .mask_err(mask_err)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_win[i] = (i == 0) ? 12'hF40 : 12'hF00;
        m_dev[i] = 2'd0;
      end
      m_pfen = 1'b0;
      m_pfcs = 0;
    end else if (wr_en) begin
      case (wr_kind)
        2'd0: m_win[wr_cs] = {wr_data[11:8], 1'b0, wr_data[6:0]};
        2'd1: m_dev[wr_cs] = wr_data[11:10];
        2'd2: begin m_pfen = wr_data[7]; m_pfcs = int'(wr_data[26:24]); end
        default: ;
      endcase
    end
  end

  task automatic check(string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h (addr 0x%08h)",
               cur_req, what, act, exp, req_addr);
    end
  endtask

  // Compare every cycle out of reset, at the falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      longint a, base, size, e_off;
      int     first, nh, e_route;
      logic [7:0] e_err;
      a = longint'(req_addr);
      first = -1; nh = 0; e_off = 0; e_route = 0; e_err = 8'h00;
      for (int i = 0; i < 8; i++) begin
        int mk;
        mk   = int'(m_win[i][11:8]);
        base = longint'(m_win[i][5:0]) * 64'h100_0000;
        size = longint'(16 - mk) * 64'h100_0000;
        if (m_win[i][6]) begin
          if (!(mk == 8 || mk == 12 || mk == 14 || mk == 15)) e_err[i] = 1'b1;
          if (a >= base && a < base + size) begin
            nh++;
            if (first < 0) begin
              first = i;
              e_off = a & (size - 1);
              if (m_dev[i] == 2'd0) e_route = 1;
              else if (m_pfen && m_pfcs == i) e_route = 3;
              else e_route = 2;
            end
          end
        end
      end
      check("cs_sel",    cs_sel,    (first < 0) ? 0 : (longint'(1) << first));
      check("cs_hit",    cs_hit,    (first >= 0) ? 1 : 0);
      check("cs_offset", cs_offset, e_off);
      check("cs_route",  cs_route,  e_route);
      check("multi_hit", multi_hit, (nh > 1) ? 1 : 0);
      check("mask_err",  mask_err,  e_err);
    end
  end

  task automatic write_cfg(input logic [1:0] kind, input int cs, input logic [31:0] data);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_kind = kind; wr_cs = 3'(cs); wr_data = data;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic probe(input logic [31:0] addr);
    @(posedge clk); #2;
    req_addr = addr;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // Reset state, checked directly before any configuration: R2
    #1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    req_addr = 32'h0012_3456;
    @(negedge clk);
    cur_req = "R2";
    check("reset sel",    cs_sel,    8'h01);
    check("reset offset", cs_offset, 32'h0012_3456);
    check("reset route",  cs_route,  2'd1);
    probe(32'h00FF_FFFF);
    probe(32'h0100_0000);
    probe(32'h3F00_0000);

    // Window range and size: R3, R5
    cur_req = "R3";
    write_cfg(2'd0, 1, 32'h0000_0C42);  // base 2, mask C, valid -> 64 MB
    probe(32'h01FF_FFFF); probe(32'h0200_0000);
    probe(32'h05FF_FFFF); probe(32'h0600_0000);
    cur_req = "R5";
    probe(32'h0412_3457); probe(32'h0355_AA01);

    // Dropped bits: R1 (bit 7 and upper bits ignored, mask 0 illegal by default)
    cur_req = "R1";
    write_cfg(2'd0, 2, 32'hFFFF_F0C8);
    probe(32'h0800_0000); probe(32'h17FF_FFFF); probe(32'h1800_0000);
    write_cfg(2'd0, 2, 32'hABCD_EF80);  // valid bit clear after masking
    probe(32'h0800_0000);

    // Invalid windows never hit: R4
    cur_req = "R4";
    write_cfg(2'd0, 3, 32'h0000_0F10);
    probe(32'h1000_0000); probe(32'h1080_0000);

    // Mask legality sweep: R6
    cur_req = "R6";
    for (int m = 0; m < 16; m++) begin
      write_cfg(2'd0, 4, (32'(m) << 8) | 32'h60);
      probe(32'h2000_0000 + 32'(m) * 32'h0100_0000 + 32'h10);
      probe(32'h2EFF_FFFF);
    end
    write_cfg(2'd0, 4, 32'h0000_0F60);

    // Overlap priority: R7
    cur_req = "R7";
    write_cfg(2'd0, 6, 32'h0000_0E70);  // base 0x30, 32 MB
    write_cfg(2'd0, 5, 32'h0000_0F71);  // base 0x31, 16 MB
    probe(32'h3000_0004); probe(32'h3100_0004); probe(32'h31FF_FFFF);
    write_cfg(2'd0, 5, 32'h0000_0E70);
    probe(32'h3180_0000);

    // Device class routing: R8
    cur_req = "R8";
    write_cfg(2'd1, 5, 32'h0000_0800); probe(32'h3000_0100);
    write_cfg(2'd1, 5, 32'h0000_0400); probe(32'h3000_0200);
    write_cfg(2'd1, 5, 32'hFFFF_F3FF); probe(32'h3000_0300);
    write_cfg(2'd1, 5, 32'h0000_0800);

    // Prefetch claim: R9
    cur_req = "R9";
    write_cfg(2'd2, 0, 32'h0500_0080); probe(32'h3000_0400);
    write_cfg(2'd2, 0, 32'h0600_0080); probe(32'h3000_0500);
    write_cfg(2'd2, 0, 32'h0500_0000); probe(32'h3000_0600);
    write_cfg(2'd2, 0, 32'h0000_0080); probe(32'h0000_0700);
    write_cfg(2'd2, 0, 32'h0500_0080);

    // Write timing against a held address: R10
    cur_req = "R10";
    probe(32'h3000_0800);
    write_cfg(2'd0, 5, 32'h0000_0000);
    write_cfg(2'd0, 6, 32'h0000_0000);
    write_cfg(2'd0, 6, 32'h0000_0E70);

    // Miss behaviour: R11
    cur_req = "R11";
    probe(32'hFFFF_FFFF); probe(32'h4000_0000); probe(32'h2F00_0000);

    // Mixed random traffic
    cur_req = "R3";
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0)      write_cfg(2'd0, int'($urandom_range(0, 7)), $urandom);
      else if (r == 1) write_cfg(2'd1, int'($urandom_range(0, 7)), $urandom);
      else if (r == 2) write_cfg(2'd2, 0, $urandom);
      else             probe({2'b00, 30'($urandom)});
    end

    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule